// File: doc/BRIEF.md
# Seven-Function Shared-Adder ALU

This block is a purely combinational arithmetic and logic unit. It takes two operands and a 3-bit operation code, and produces a result and a flag that is high when the result is zero. It supports seven operations: add, subtract, bitwise AND, OR and XOR, a left shift and a logical right shift. The eighth code gives zero. There is no clock and there are no registers inside. The output settles from the inputs alone, so the block can sit in the execute stage of a multicycle datapath, with its result captured by an external register.

Add and subtract use one ripple chain of full adders. Each bit of the second operand passes through an XOR gate controlled by the subtract line. The same line drives the carry into the lowest bit, which supplies the "+1" of two's complement negation. No separate subtractor exists. The shifters move the first operand by the amount held in the low bits of the second operand. A parameter selects either a logarithmic stage shifter or a flat mux shifter.

Top module: `alu7_core`

## Requirements
- R1: With op_sel = 3'b000 (add), result equals (opnd_a + opnd_b) modulo 2^32, and any carry out of bit 31 is discarded.
- R2: With op_sel = 3'b001 (subtract), result equals (opnd_a - opnd_b) modulo 2^32. It is formed on the same adder chain, with opnd_b inverted and a carry-in of one.
- R3: With op_sel = 3'b010, result is the bitwise AND of the operands.
- R4: With op_sel = 3'b011, result is the bitwise OR of the operands.
- R5: With op_sel = 3'b100, result is the bitwise XOR of the operands.
- R6: With op_sel = 3'b101, result is opnd_a shifted left by opnd_b[4:0], with zeros filled in. Bits 31:5 of opnd_b have no effect.
- R7: With op_sel = 3'b110, result is opnd_a shifted right logically by opnd_b[4:0], with zeros filled in from the top. Bits 31:5 of opnd_b have no effect.
- R8: With op_sel = 3'b111, result is all zeros and is_zero is high, whatever the operands are.
- R9: is_zero is high exactly when all 32 result bits are zero, for every operation.
- R10: The outputs follow any change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that gets shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 3 | Operation code |
| result | output | 32 | Result of the selected operation |
| is_zero | output | 1 | High when result is all zeros |

## Verification
Carries that wrap are the main target. Adding one to all ones, and subtracting a larger value from a smaller one, both check wrap-around. A design that dropped the carry-in of one on subtract would come out one low. Subtracting equal operands must give zero and raise is_zero; a flag wired to the wrong bits would stay low. The shifts are driven with amounts 0 and 31, and with amounts whose bits above bit 4 are set. A shifter that looked at those upper bits, or that filled a right shift with the sign bit, would give a different value. Code 111 is applied with nonzero operands to catch a default arm that leaks an operand through.

// File: rtl/alu7_pkg.sv
package alu7_pkg;

   localparam int unsigned ALU_W = 32;
   localparam int unsigned OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 3'b000,
      OPC_SUB  = 3'b001,
      OPC_AND  = 3'b010,
      OPC_OR   = 3'b011,
      OPC_XOR  = 3'b100,
      OPC_SHL  = 3'b101,
      OPC_SHR  = 3'b110,
      OPC_NONE = 3'b111
   } alu7_opc_e;

   typedef enum logic {
      SH_LEFT  = 1'b0,
      SH_RIGHT = 1'b1
   } alu7_shdir_e;

endpackage

// File: rtl/alu7_xor_cond.sv
module alu7_xor_cond #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] b_in,
   input  logic         invert,
   output logic [W-1:0] b_out
);

   generate
      if (W < 1) begin : bad_w
         $error("alu7_xor_cond: W must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_bit
         assign b_out[i] = b_in[i] ^ invert;
      end
   endgenerate

   always_comb begin
      if (!$isunknown({b_in, invert})) begin
         // R2
         cond_pass_chk: assert ((b_out ^ b_in) == {W{invert}})
            else $error("operand conditioner mismatch");
      end
   end

endmodule

// File: rtl/alu7_ripple_adder.sv
module alu7_ripple_adder #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum
);

   generate
      if (W < 1) begin : bad_w
         $error("alu7_ripple_adder: W must be at least 1");
      end
   endgenerate

   logic [W:0] carry;
   assign carry[0] = cin;

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_fa
         logic p, g;
         assign p            = x[i] ^ y[i];
         assign g            = x[i] & y[i];
         assign sum[i]       = p ^ carry[i];
         assign carry[i+1]   = g | (p & carry[i]);
      end
   endgenerate

   logic [W:0] ref_total;
   always_comb begin
      ref_total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
      if (!$isunknown({x, y, cin})) begin
         // R1
         chain_sum_chk: assert ({carry[W], sum} == ref_total)
            else $error("ripple chain disagrees with arithmetic sum");
      end
   end

endmodule

// File: rtl/alu7_shifter.sv
module alu7_shifter #(
   parameter int unsigned W         = 32,
   parameter bit          LOG_STAGE = 1'b1,
   localparam int unsigned AW       = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [AW-1:0] amt,
   input  logic          dir_right,
   output logic [W-1:0]  dout
);

   generate
      if (W < 2 || (W & (W - 1)) != 0) begin : bad_w
         $error("alu7_shifter: W must be a power of two, at least 2");
      end
   endgenerate

   genvar s;
   generate
      if (LOG_STAGE) begin : g_log
         logic [W-1:0] stage [AW+1];
         assign stage[0] = din;
         for (s = 0; s < AW; s++) begin : g_stage
            localparam int unsigned STEP = 1 << s;
            logic [W-1:0] moved;
            assign moved = dir_right ? (stage[s] >> STEP) : (stage[s] << STEP);
            assign stage[s+1] = amt[s] ? moved : stage[s];
         end
         assign dout = stage[AW];
      end else begin : g_flat
         logic [W-1:0] cand_l [W];
         logic [W-1:0] cand_r [W];
         for (s = 0; s < W; s++) begin : g_cand
            assign cand_l[s] = din << s;
            assign cand_r[s] = din >> s;
         end
         assign dout = dir_right ? cand_r[amt] : cand_l[amt];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({din, amt, dir_right})) begin
         // R7
         shr_fill_chk: assert (!dir_right || amt == '0 ||
                               dout[W-1] == 1'b0)
            else $error("right shift did not fill with zero");
         // R6
         shl_fill_chk: assert (dir_right || amt == '0 || dout[0] == 1'b0)
            else $error("left shift did not fill with zero");
      end
   end

endmodule

// File: rtl/alu7_core.sv
module alu7_core
   import alu7_pkg::*;
#(
   parameter int unsigned W         = ALU_W,
   parameter bit          LOG_STAGE = 1'b1,
   localparam int unsigned AW       = $clog2(W)
) (
   input  logic [W-1:0]     opnd_a,
   input  logic [W-1:0]     opnd_b,
   input  logic [OPC_W-1:0] op_sel,
   output logic [W-1:0]     result,
   output logic             is_zero
);

   generate
      if (W < 2 || (W & (W - 1)) != 0) begin : bad_w
         $error("alu7_core: W must be a power of two, at least 2");
      end
   endgenerate

   alu7_opc_e opc;
   assign opc = alu7_opc_e'(op_sel);

   logic           do_sub;
   logic [W-1:0]   b_cond;
   logic [W-1:0]   arith;
   logic [W-1:0]   shifted;
   logic           shr_sel;

   assign do_sub  = (opc == OPC_SUB);
   assign shr_sel = (opc == OPC_SHR);

   alu7_xor_cond #(.W(W)) u_cond (
      .b_in   (opnd_b),
      .invert (do_sub),
      .b_out  (b_cond)
   );

   alu7_ripple_adder #(.W(W)) u_add (
      .x   (opnd_a),
      .y   (b_cond),
      .cin (do_sub),
      .sum (arith)
   );

   alu7_shifter #(.W(W), .LOG_STAGE(LOG_STAGE)) u_shift (
      .din       (opnd_a),
      .amt       (opnd_b[AW-1:0]),
      .dir_right (shr_sel),
      .dout      (shifted)
   );

   always_comb begin
      unique case (opc)
         OPC_ADD, OPC_SUB: result = arith;
         OPC_AND:          result = opnd_a & opnd_b;
         OPC_OR:           result = opnd_a | opnd_b;
         OPC_XOR:          result = opnd_a ^ opnd_b;
         OPC_SHL, OPC_SHR: result = shifted;
         default:          result = '0;
      endcase
   end

   assign is_zero = ~|result;

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
         // R2
         sub_inverse_chk: assert (opc != OPC_SUB || result + opnd_b == opnd_a)
            else $error("difference plus subtrahend is not the minuend");
         // R1
         add_inverse_chk: assert (opc != OPC_ADD || result - opnd_b == opnd_a)
            else $error("sum minus addend is not the augend");
         // R3
         and_subset_chk: assert (opc != OPC_AND || (result & ~opnd_a) == '0)
            else $error("AND result has bits outside operand a");
         // R4
         or_superset_chk: assert (opc != OPC_OR || (opnd_a & ~result) == '0)
            else $error("OR result lost bits of operand a");
         // R8
         none_zero_chk: assert (opc != OPC_NONE || is_zero)
            else $error("unused code did not give zero");
      end
   end

endmodule

// File: tb/sim_alu7_core.sv
module sim_alu7_core;

   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 3000;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic [31:0] a, b;
   logic [2:0]  op;
   logic [31:0] res;
   logic        zf;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu7_core u0 (
      .opnd_a  (a),
      .opnd_b  (b),
      .op_sel  (op),
      .result  (res),
      .is_zero (zf)
   );

   function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                         input logic [2:0] c);
      case (c)
         3'b000: return x + y;
         3'b001: return x - y;
         3'b010: return x & y;
         3'b011: return x | y;
         3'b100: return x ^ y;
         3'b101: return x << y[4:0];
         3'b110: return x >> y[4:0];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b100: return "R5";
         3'b101: return "R6";
         3'b110: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (a=%h b=%h op=%b)", req, act, exp, a, b, op);
      end
   endtask

   task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [2:0] c);
      logic [31:0] e;
      @(negedge clk);
      a = x; b = y; op = c;
      #1;
      e = model(x, y, c);
      check(req_of(c), res, e);
      check("R9", {31'b0, zf}, {31'b0, e == 32'h0});
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      a = '0; b = '0; op = 3'b000;
      #1;
      // initial state: 0 + 0 = 0, flag high (R1, R9)
      check("R1", res, 32'h0);
      check("R9", {31'b0, zf}, 32'h1);

      // R1 wrap-around
      apply(32'hFFFF_FFFF, 32'h1, 3'b000);
      apply(32'h8000_0000, 32'h8000_0000, 3'b000);
      // R2 borrow, equal operands, zero minus one
      apply(32'h5, 32'h9, 3'b001);
      apply(32'h1234_5678, 32'h1234_5678, 3'b001);
      apply(32'h0, 32'h1, 3'b001);
      apply(32'h8000_0000, 32'h1, 3'b001);
      // R3, R4, R5
      apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'b010);
      apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 3'b011);
      apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 3'b100);
      // R6 amounts 0, 31, and upper bits of b ignored
      apply(32'h8000_0001, 32'h0, 3'b101);
      apply(32'h8000_0001, 32'h1F, 3'b101);
      apply(32'h0000_0003, 32'hFFFF_FFE4, 3'b101);
      apply(32'h0000_0003, 32'h20, 3'b101);
      // R7 logical fill and ignored upper bits
      apply(32'h8000_0000, 32'h1F, 3'b110);
      apply(32'hF000_0000, 32'h4, 3'b110);
      apply(32'hF000_0000, 32'hFFFF_FFE4, 3'b110);
      // R8 unused code with nonzero operands
      apply(32'hDEAD_BEEF, 32'hCAFE_F00D, 3'b111);
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111);

      // R10: input change with no clock edge between, output settles at once
      @(posedge clk);
      #2;
      a = 32'h0000_0010; b = 32'h0000_0020; op = 3'b000;
      #1;
      check("R10", res, 32'h0000_0030);
      a = 32'h0000_0100;
      #1;
      check("R10", res, 32'h0000_0120);

      for (int i = 0; i < N_RAND; i++) begin
         logic [31:0] x, y;
         logic [2:0]  c;
         x = $urandom;
         y = $urandom;
         c = 3'($urandom % 8);
         if ((i % 16) == 0) y = x;
         if ((i % 23) == 0) x = 32'h0;
         apply(x, y, c);
      end

      finish_run();
   end

endmodule